// File: doc/BRIEF.md
# Multiprocessor Boot and Run Controller

This block is a memory-mapped control unit for a small multiprocessor cluster. Any core can query which core it is, how many cores the cluster holds and how much memory the system has, and can program one shared start address and one shared start stack value. Software then brings further cores up by writing a target core index to a launch register. It can also freeze or release every core except a named one, typically the caller itself.

Each bus access carries the requesting core's ID, and reads answer one cycle later. The block drives one running flag per core. It also drives a per-core load strobe that pulses for a single cycle when that core is launched, while the program counter and stack pointer values for the core sit on two shared 64-bit outputs.

Register offsets are byte offsets on 8-byte slots: identity 0x00, core count 0x08, memory size 0x10, start address 0x18, start stack 0x20, launch 0x28, pause 0x30, resume 0x38.

Top module: `mp_boot_ctrl`

## Requirements
- R1: A read of offset 0x00 returns the requesting core's ID, zero-extended to 64 bits, on `rsp_rdata` in the cycle after the request.
- R2: A read of offset 0x08 returns NUM_CORES, and a write to offset 0x08 changes nothing.
- R3: A read of offset 0x10 returns RAM_MB multiplied by 1048576.
- R4: After reset the start address (0x18) reads RESET_PC and the start stack (0x20) reads RESET_SP. All running flags and load strobes are 0.
- R5: A write to 0x18 or 0x20 with `req_is32`=1 stores bits 31:0 of the write data sign-extended from bit 31, ignoring bits 63:32. With `req_is32`=0 it stores all 64 bits unchanged.
- R6: Writing an index k < NUM_CORES to 0x28 raises `core_load[k]` alone for exactly one cycle, after the write's clock edge. In that cycle `launch_pc`/`launch_sp` hold the start values in force at the write, and `core_running[k]` is 1 from then on.
- R7: Writing an index k < NUM_CORES to 0x30 clears every running flag except bit k, which keeps its value.
- R8: Writing an index k < NUM_CORES to 0x38 sets every running flag except bit k, which keeps its value.
- R9: A write of an index ≥ NUM_CORES to 0x28, 0x30 or 0x38 leaves running flags unchanged and produces no load strobe.
- R10: A read of any offset other than 0x00, 0x08, 0x10, 0x18 or 0x20 returns zero, and a write to an unmapped offset changes no state.
- R11: `rsp_valid` is 1 exactly in the cycle after a read request and 0 after writes and idle cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_is32 | input | 1 | Write carries a 32-bit value |
| req_offset | input | 8 | Byte offset of the register |
| req_wdata | input | 64 | Write data |
| req_core_id | input | CID_W | ID of the requesting core |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 64 | Read data |
| core_running | output | NUM_CORES | Per-core running flag |
| core_load | output | NUM_CORES | Per-core one-cycle launch strobe |
| launch_pc | output | 64 | Program counter for the launched core |
| launch_sp | output | 64 | Stack pointer for the launched core |

## Verification
The hardest state to reach from the ports is a mixed running vector, where some cores run and others are stopped. Pause and resume only ever exempt a single core, so such a vector arises only from a particular ordering of launches, pauses and resumes. The stimulus builds it on purpose with a launch, then a pause naming a different core, then a resume naming a third. A long random sequence then interleaves those three commands with out-of-range indices and start-value rewrites, and checks the whole vector after every command.

// File: rtl/mpctl_pkg.sv
package mpctl_pkg;

    localparam int DW   = 64;
    localparam int OFFW = 8;

    localparam logic [OFFW-1:0] OFF_WHO    = 8'h00;
    localparam logic [OFFW-1:0] OFF_COUNT  = 8'h08;
    localparam logic [OFFW-1:0] OFF_MEM    = 8'h10;
    localparam logic [OFFW-1:0] OFF_PC     = 8'h18;
    localparam logic [OFFW-1:0] OFF_SP     = 8'h20;
    localparam logic [OFFW-1:0] OFF_LAUNCH = 8'h28;
    localparam logic [OFFW-1:0] OFF_PAUSE  = 8'h30;
    localparam logic [OFFW-1:0] OFF_RESUME = 8'h38;

    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_WHO,
        SEL_COUNT,
        SEL_MEM,
        SEL_PC,
        SEL_SP,
        SEL_LAUNCH,
        SEL_PAUSE,
        SEL_RESUME
    } reg_sel_e;

    typedef struct packed {
        logic          wr_pc;
        logic          wr_sp;
        logic          launch;
        logic          pause;
        logic          resume;
        logic          is32;
        logic [DW-1:0] data;
    } ctl_cmd_t;

    function automatic reg_sel_e decode_off(input logic [OFFW-1:0] off);
        reg_sel_e s;
        case (off)
            OFF_WHO:    s = SEL_WHO;
            OFF_COUNT:  s = SEL_COUNT;
            OFF_MEM:    s = SEL_MEM;
            OFF_PC:     s = SEL_PC;
            OFF_SP:     s = SEL_SP;
            OFF_LAUNCH: s = SEL_LAUNCH;
            OFF_PAUSE:  s = SEL_PAUSE;
            OFF_RESUME: s = SEL_RESUME;
            default:    s = SEL_NONE;
        endcase
        return s;
    endfunction

    // Narrow writes carry a signed 32-bit quantity in the low half.
    function automatic logic [DW-1:0] widen_word(input logic [DW-1:0] d,
                                                 input logic          is32);
        return is32 ? {{32{d[31]}}, d[31:0]} : d;
    endfunction

endpackage

// File: rtl/mpctl_access.sv
module mpctl_access
    import mpctl_pkg::*;
#(
    parameter int              NUM_CORES = 4,
    parameter int              CID_W     = 2,
    parameter logic [DW-1:0]   MEM_BYTES = 64'd268435456
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic             req_is32,
    input  logic [OFFW-1:0]  req_offset,
    input  logic [DW-1:0]    req_wdata,
    input  logic [CID_W-1:0] req_core_id,
    input  logic [DW-1:0]    start_pc,
    input  logic [DW-1:0]    start_sp,
    output ctl_cmd_t         cmd,
    output logic             rsp_valid,
    output logic [DW-1:0]    rsp_rdata
);

    reg_sel_e      sel;
    logic          wr_en;
    logic          rd_en;
    logic [DW-1:0] rd_mux;

    assign sel   = decode_off(req_offset);
    assign wr_en = req_valid && req_write;
    assign rd_en = req_valid && !req_write;

    always_comb begin
        cmd        = '0;
        cmd.is32   = req_is32;
        cmd.data   = req_wdata;
        cmd.wr_pc  = wr_en && (sel == SEL_PC);
        cmd.wr_sp  = wr_en && (sel == SEL_SP);
        cmd.launch = wr_en && (sel == SEL_LAUNCH);
        cmd.pause  = wr_en && (sel == SEL_PAUSE);
        cmd.resume = wr_en && (sel == SEL_RESUME);
    end

    always_comb begin
        case (sel)
            SEL_WHO:   rd_mux = DW'(req_core_id);
            SEL_COUNT: rd_mux = DW'(NUM_CORES);
            SEL_MEM:   rd_mux = MEM_BYTES;
            SEL_PC:    rd_mux = start_pc;
            SEL_SP:    rd_mux = start_sp;
            default:   rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= rd_en;
            rsp_rdata <= rd_en ? rd_mux : '0;
        end
    end

endmodule

// File: rtl/mpctl_regbank.sv
module mpctl_regbank
    import mpctl_pkg::*;
#(
    parameter logic [DW-1:0] RESET_PC = 64'h0000_0000_0000_1000,
    parameter logic [DW-1:0] RESET_SP = 64'h0000_0000_0008_0000
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_pc,
    input  logic          wr_sp,
    input  logic          is32,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] start_pc,
    output logic [DW-1:0] start_sp
);

    logic [DW-1:0] wide;

    assign wide = widen_word(wdata, is32);

    always_ff @(posedge clk) begin
        if (rst) begin
            start_pc <= RESET_PC;
            start_sp <= RESET_SP;
        end else begin
            if (wr_pc) start_pc <= wide;
            if (wr_sp) start_sp <= wide;
        end
    end

endmodule

// File: rtl/mpctl_run_ctrl.sv
module mpctl_run_ctrl
    import mpctl_pkg::*;
#(
    parameter int NUM_CORES = 4,
    parameter int CID_W     = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 do_launch,
    input  logic                 do_pause,
    input  logic                 do_resume,
    input  logic [DW-1:0]        target,
    input  logic [DW-1:0]        start_pc,
    input  logic [DW-1:0]        start_sp,
    output logic [NUM_CORES-1:0] running,
    output logic [NUM_CORES-1:0] load,
    output logic [DW-1:0]        launch_pc,
    output logic [DW-1:0]        launch_sp
);

    logic             tgt_ok;
    logic [CID_W-1:0] tgt_idx;

    assign tgt_ok  = target < DW'(NUM_CORES);
    assign tgt_idx = target[CID_W-1:0];

    for (genvar i = 0; i < NUM_CORES; i++) begin : g_core
        logic hit;
        assign hit = tgt_ok && (tgt_idx == CID_W'(i));

        always_ff @(posedge clk) begin
            if (rst) begin
                running[i] <= 1'b0;
                load[i]    <= 1'b0;
            end else begin
                load[i] <= do_launch && hit;
                if (do_launch && hit)
                    running[i] <= 1'b1;
                else if (do_pause && tgt_ok && !hit)
                    running[i] <= 1'b0;
                else if (do_resume && tgt_ok && !hit)
                    running[i] <= 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            launch_pc <= '0;
            launch_sp <= '0;
        end else if (do_launch && tgt_ok) begin
            launch_pc <= start_pc;
            launch_sp <= start_sp;
        end
    end

endmodule

// File: rtl/mp_boot_ctrl.sv
module mp_boot_ctrl
    import mpctl_pkg::*;
#(
    parameter int              NUM_CORES = 4,
    parameter longint unsigned RAM_MB    = 256,
    parameter logic [63:0]     RESET_PC  = 64'h0000_0000_0000_1000,
    parameter logic [63:0]     RESET_SP  = 64'h0000_0000_0008_0000,
    localparam int             CID_W     = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid,
    input  logic                 req_write,
    input  logic                 req_is32,
    input  logic [7:0]           req_offset,
    input  logic [63:0]          req_wdata,
    input  logic [CID_W-1:0]     req_core_id,
    output logic                 rsp_valid,
    output logic [63:0]          rsp_rdata,
    output logic [NUM_CORES-1:0] core_running,
    output logic [NUM_CORES-1:0] core_load,
    output logic [63:0]          launch_pc,
    output logic [63:0]          launch_sp
);

    localparam logic [DW-1:0] MEM_BYTES = DW'(RAM_MB) << 20;

    ctl_cmd_t      cmd;
    logic [DW-1:0] start_pc;
    logic [DW-1:0] start_sp;

    mpctl_access #(
        .NUM_CORES (NUM_CORES),
        .CID_W     (CID_W),
        .MEM_BYTES (MEM_BYTES)
    ) u_access (
        .clk         (clk),
        .rst         (rst),
        .req_valid   (req_valid),
        .req_write   (req_write),
        .req_is32    (req_is32),
        .req_offset  (req_offset),
        .req_wdata   (req_wdata),
        .req_core_id (req_core_id),
        .start_pc    (start_pc),
        .start_sp    (start_sp),
        .cmd         (cmd),
        .rsp_valid   (rsp_valid),
        .rsp_rdata   (rsp_rdata)
    );

    mpctl_regbank #(
        .RESET_PC (RESET_PC),
        .RESET_SP (RESET_SP)
    ) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_pc    (cmd.wr_pc),
        .wr_sp    (cmd.wr_sp),
        .is32     (cmd.is32),
        .wdata    (cmd.data),
        .start_pc (start_pc),
        .start_sp (start_sp)
    );

    mpctl_run_ctrl #(
        .NUM_CORES (NUM_CORES),
        .CID_W     (CID_W)
    ) u_run (
        .clk       (clk),
        .rst       (rst),
        .do_launch (cmd.launch),
        .do_pause  (cmd.pause),
        .do_resume (cmd.resume),
        .target    (cmd.data),
        .start_pc  (start_pc),
        .start_sp  (start_sp),
        .running   (core_running),
        .load      (core_load),
        .launch_pc (launch_pc),
        .launch_sp (launch_sp)
    );

endmodule

// File: rtl/mpctl_checker.sv
module mpctl_checker
    import mpctl_pkg::*;
#(
    parameter int NUM_CORES = 4,
    localparam int CID_W = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 req_valid,
    input logic                 req_write,
    input logic [7:0]           req_offset,
    input logic [63:0]          req_wdata,
    input logic [CID_W-1:0]     req_core_id,
    input logic                 rsp_valid,
    input logic [63:0]          rsp_rdata,
    input logic [NUM_CORES-1:0] core_running,
    input logic [NUM_CORES-1:0] core_load
);

    logic                 rd_req;
    logic                 wr_req;
    logic                 idx_ok;
    logic                 run_cmd;
    logic [NUM_CORES-1:0] spare;

    assign rd_req  = req_valid && !req_write;
    assign wr_req  = req_valid && req_write;
    assign idx_ok  = req_wdata < 64'(NUM_CORES);
    assign run_cmd = (req_offset == OFF_LAUNCH) || (req_offset == OFF_PAUSE) ||
                     (req_offset == OFF_RESUME);
    assign spare   = NUM_CORES'(1) << req_wdata[CID_W-1:0];

    p_id_r1: assert property (@(posedge clk) disable iff (rst)
        (rd_req && req_offset == OFF_WHO) |=> rsp_rdata == 64'($past(req_core_id)));

    p_count_r2: assert property (@(posedge clk) disable iff (rst)
        (rd_req && req_offset == OFF_COUNT) |=> rsp_rdata == 64'(NUM_CORES));

    p_load_onehot_r6: assert property (@(posedge clk) disable iff (rst)
        $onehot0(core_load));

    p_load_runs_r6: assert property (@(posedge clk) disable iff (rst)
        (core_load & ~core_running) == '0);

    p_pause_r7: assert property (@(posedge clk) disable iff (rst)
        (wr_req && req_offset == OFF_PAUSE && idx_ok) |=>
        (core_running & ~$past(spare)) == '0);

    p_resume_r8: assert property (@(posedge clk) disable iff (rst)
        (wr_req && req_offset == OFF_RESUME && idx_ok) |=>
        (core_running | $past(spare)) == '1);

    p_ignore_r9: assert property (@(posedge clk) disable iff (rst)
        (wr_req && run_cmd && !idx_ok) |=> ($stable(core_running) && core_load == '0));

    p_unmapped_r10: assert property (@(posedge clk) disable iff (rst)
        (rd_req && decode_off(req_offset) == SEL_NONE) |=> rsp_rdata == '0);

    p_rsp_r11: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $past(rd_req));

endmodule

bind mp_boot_ctrl mpctl_checker #(.NUM_CORES(NUM_CORES)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .req_valid    (req_valid),
    .req_write    (req_write),
    .req_offset   (req_offset),
    .req_wdata    (req_wdata),
    .req_core_id  (req_core_id),
    .rsp_valid    (rsp_valid),
    .rsp_rdata    (rsp_rdata),
    .core_running (core_running),
    .core_load    (core_load)
);

// File: tb/sim_mp_boot_ctrl.sv
module sim_mp_boot_ctrl;

    localparam int          CLK_PERIOD = 10;
    localparam int          N          = 4;
    localparam longint      MB         = 256;
    localparam logic [63:0] RPC        = 64'h0000_0000_0000_1000;
    localparam logic [63:0] RSP        = 64'h0000_0000_0008_0000;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         req_valid = 1'b0;
    logic         req_write = 1'b0;
    logic         req_is32 = 1'b0;
    logic [7:0]   req_offset = '0;
    logic [63:0]  req_wdata = '0;
    logic [1:0]   req_core_id = '0;
    logic         rsp_valid;
    logic [63:0]  rsp_rdata;
    logic [N-1:0] core_running;
    logic [N-1:0] core_load;
    logic [63:0]  launch_pc;
    logic [63:0]  launch_sp;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [63:0]  m_pc  = RPC;
    logic [63:0]  m_sp  = RSP;
    logic [N-1:0] m_run = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mp_boot_ctrl #(.NUM_CORES(N), .RAM_MB(MB), .RESET_PC(RPC), .RESET_SP(RSP)) u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_is32(req_is32), .req_offset(req_offset), .req_wdata(req_wdata),
        .req_core_id(req_core_id), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .core_running(core_running), .core_load(core_load),
        .launch_pc(launch_pc), .launch_sp(launch_sp)
    );

    function automatic logic [63:0] sext(input logic [63:0] d, input bit w32);
        return w32 ? {{32{d[31]}}, d[31:0]} : d;
    endfunction

    function automatic logic [63:0] exp_read(input logic [7:0] off, input logic [1:0] id);
        case (off)
            8'h00:   return 64'(id);
            8'h08:   return 64'(N);
            8'h10:   return 64'(MB) * 64'd1048576;
            8'h18:   return m_pc;
            8'h20:   return m_sp;
            default: return 64'd0;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic access(input bit wr, input bit w32, input logic [7:0] off,
                          input logic [63:0] d, input logic [1:0] id);
        req_valid   = 1'b1;
        req_write   = wr;
        req_is32    = w32;
        req_offset  = off;
        req_wdata   = d;
        req_core_id = id;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        req_write = 1'b0;
    endtask

    task automatic rd(input logic [7:0] off, input logic [1:0] id, input string tag);
        access(0, 0, off, 64'd0, id);
        chk({tag, " R11 valid"}, 64'(rsp_valid), 64'd1);
        chk(tag, rsp_rdata, exp_read(off, id));
    endtask

    task automatic wr_start(input bit sp, input bit w32, input logic [63:0] d);
        access(1, w32, sp ? 8'h20 : 8'h18, d, 2'd0);
        chk("R11 no rsp on write", 64'(rsp_valid), 64'd0);
        if (sp) m_sp = sext(d, w32);
        else    m_pc = sext(d, w32);
    endtask

    task automatic launch(input logic [63:0] idx);
        bit ok = idx < 64'(N);
        string t = ok ? "R6" : "R9";
        access(1, 0, 8'h28, idx, 2'd1);
        chk({t, " load strobe"}, 64'(core_load), ok ? 64'(1) << idx : 64'd0);
        if (ok) begin
            chk("R6 pc", launch_pc, m_pc);
            chk("R6 sp", launch_sp, m_sp);
            m_run[idx[1:0]] = 1'b1;
        end
        chk({t, " running"}, 64'(core_running), 64'(m_run));
        @(posedge clk);
        @(negedge clk);
        chk("R6 pulse one cycle", 64'(core_load), 64'd0);
    endtask

    task automatic pause_resume(input bit res, input logic [63:0] idx);
        bit ok = idx < 64'(N);
        string t = !ok ? "R9" : (res ? "R8" : "R7");
        access(1, 0, res ? 8'h38 : 8'h30, idx, 2'd2);
        if (ok)
            for (int i = 0; i < N; i++)
                if (i != int'(idx)) m_run[i] = res;
        chk({t, " running"}, 64'(core_running), 64'(m_run));
        chk({t, " no load"}, 64'(core_load), 64'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R4 reset state
        chk("R4 running after reset", 64'(core_running), 64'd0);
        chk("R4 load after reset", 64'(core_load), 64'd0);
        chk("R11 idle", 64'(rsp_valid), 64'd0);
        rd(8'h18, 2'd0, "R4 start pc default");
        rd(8'h20, 2'd0, "R4 start sp default");

        // R1 identity for every core
        for (int i = 0; i < N; i++) rd(8'h00, 2'(i), "R1 identity");

        // R2 count, write ignored
        rd(8'h08, 2'd3, "R2 count");
        access(1, 0, 8'h08, 64'd77, 2'd0);
        rd(8'h08, 2'd0, "R2 count after write");

        // R3 memory size
        rd(8'h10, 2'd1, "R3 memory bytes");

        // R5 extension
        wr_start(0, 1, 64'h1234_5678_8000_0000);
        rd(8'h18, 2'd0, "R5 sext negative");
        chk("R5 literal", m_pc, 64'hFFFF_FFFF_8000_0000);
        wr_start(1, 1, 64'h0000_0000_7FFF_FFFF);
        rd(8'h20, 2'd0, "R5 positive 32");
        wr_start(1, 0, 64'h0000_0000_8000_0000);
        rd(8'h20, 2'd0, "R5 64-bit no extend");
        chk("R5 literal 64", m_sp, 64'h0000_0000_8000_0000);

        // R6..R9 directed: build a mixed running vector
        launch(64'd2);
        pause_resume(0, 64'd1);
        pause_resume(1, 64'd0);
        pause_resume(0, 64'd3);
        launch(64'd4);
        launch(64'hFFFF_FFFF_FFFF_FFFF);
        pause_resume(0, 64'd5);
        pause_resume(1, 64'h1_0000_0000);

        // R10 unmapped
        rd(8'h09, 2'd0, "R10 misaligned read");
        rd(8'h40, 2'd0, "R10 high read");
        rd(8'h28, 2'd0, "R10 launch reads zero");
        access(1, 0, 8'h1C, 64'hDEAD, 2'd0);
        chk("R10 running kept", 64'(core_running), 64'(m_run));
        rd(8'h18, 2'd0, "R10 pc kept");
        rd(8'h20, 2'd0, "R10 sp kept");

        // Random phase
        for (int n = 0; n < 500; n++) begin
            int k = $urandom_range(0, 5);
            logic [63:0] d = {$urandom(), $urandom()};
            case (k)
                0: wr_start(bit'($urandom_range(0, 1)), bit'($urandom_range(0, 1)), d);
                1: launch(64'($urandom_range(0, 5)));
                2: pause_resume(0, 64'($urandom_range(0, 5)));
                3: pause_resume(1, 64'($urandom_range(0, 5)));
                4: rd(8'($urandom_range(0, 79)), 2'($urandom_range(0, 3)), "R10 random read");
                default: begin
                    logic [7:0] off;
                    case ($urandom_range(0, 3))
                        0: off = 8'h08;
                        1: off = 8'h10;
                        2: off = 8'h00;
                        default: off = 8'h40 + 8'($urandom_range(0, 63));
                    endcase
                    access(1, 0, off, d, 2'd0);
                    chk("R10 random write ignored", 64'(core_running), 64'(m_run));
                    chk("R10 no load", 64'(core_load), 64'd0);
                end
            endcase
        end
        rd(8'h18, 2'd0, "R5 final pc");
        rd(8'h20, 2'd0, "R5 final sp");

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule